// File: doc/BRIEF.md
# Packet Crossbar with Open Output Acceptance

This block joins a set of input packet queues to the same number of output packet queues. Each input queue takes one packet per cycle from its producer, made of a destination index and a payload. Every cycle a scheduler looks only at the head packet of each input queue and decides which heads move into their output queues on the next clock edge. Consumers drain the output queues through a simple pop interface. The head payload is visible while the valid flag is high.

Two scheduling policies are selectable at run time. In open mode the outputs do no arbitration. Inputs are visited from index 0 upwards, and each head moves if its destination still has a free slot after the inputs before it have claimed theirs. One output may therefore absorb packets from several inputs in the same cycle. In round-robin mode each output grants at most one requesting input per cycle, chosen by a rotating priority pointer per output. The other two mode codes are not supported. They raise an error flag and freeze all transfers.

The free space of each output is taken from its occupancy at the start of the cycle. A slot freed by a pop in the same cycle becomes usable one cycle later.

Top module: `pkt_xbar`

## Requirements
- R1: After reset all output queues are empty (out_valid all 0), all input queues report ready (in_ready all 1) and mode_err is 0.
- R2: Each input queue holds DEPTH packets; in_ready is 0 when it is full, and a push presented while in_ready is 0 is dropped and never reaches any output.
- R3: In open mode (mode = 2) one output accepts, in a single cycle, the head packets of every input aimed at it, up to its free slots at the start of that cycle.
- R4: In open mode inputs are served in ascending index order, so when free slots run short the lower-index inputs take them and the higher-index heads wait.
- R5: Only the head of an input queue is considered; a head whose destination is full stalls its queue, and packets behind it do not pass it even when their own destination has room.
- R6: No packet is lost, duplicated or reordered between any input and output pair, and no output ever holds more than DEPTH packets.
- R7: In round-robin mode (mode = 0) each output accepts at most one packet per cycle. The grant goes to the first requesting input at or after that output's pointer, and the pointer then moves to the input after the one granted. All pointers start at input 0.
- R8: Mode codes 1 and 3 are unsupported: mode_err is 1 and no packet moves while such a code is applied.
- R9: A packet pushed into an empty input queue on clock edge k, with room at its output, shows at that output after edge k+1 and not before. The output shows its oldest packet on out_data while out_valid is 1, and out_pop removes that packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Policy: 0 round-robin, 2 open, 1 and 3 unsupported |
| in_valid | input | NPORT | Push request per input |
| in_dst | input | NPORT*DST_W | Destination index per input, input i in bits [i*DST_W +: DST_W] |
| in_data | input | NPORT*DATA_W | Payload per input, input i in bits [i*DATA_W +: DATA_W] |
| in_ready | output | NPORT | Input queue has room |
| out_pop | input | NPORT | Remove the head packet of an output queue |
| out_valid | output | NPORT | Output queue not empty |
| out_data | output | NPORT*DATA_W | Head payload per output, output d in bits [d*DATA_W +: DATA_W] |
| mode_err | output | 1 | Unsupported mode code applied |

## Verification
A wrong free-slot count would show as an output that keeps accepting past its depth, which overwrites an older entry. It would also show as a head that stays stuck while its output has room. Either one shows at the ports as a payload mismatch or a missing packet the first time that output is drained. A corrupted round-robin pointer changes which input's packet leads a contended output on the very next grant. A queue pointer that slips exposes a stale or repeated payload at the head one cycle after the bad update. The directed cases therefore freeze transfers with an unsupported mode right after one scheduling edge. That makes the number of packets moved in that single cycle visible by draining the output.

// File: rtl/pkt_xbar_pkg.sv
package pkt_xbar_pkg;

    typedef enum logic [1:0] {
        XB_ROUND = 2'd0,
        XB_MATCH = 2'd1,
        XB_OPEN  = 2'd2
    } xb_mode_e;

    function automatic logic mode_ok(input logic [1:0] m);
        return (m == XB_ROUND) || (m == XB_OPEN);
    endfunction

    function automatic int wrap_next(input int idx, input int n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/pkt_xbar_infifo.sv
module pkt_xbar_infifo #(
    parameter int DATA_W = 8,
    parameter int DST_W  = 2,
    parameter int DEPTH  = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  logic [DST_W-1:0]             push_dst,
    input  logic [DATA_W-1:0]            push_data,
    input  logic                         pop,
    output logic                         ready,
    output logic                         head_valid,
    output logic [DST_W-1:0]             head_dst,
    output logic [DATA_W-1:0]            head_data,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DST_W-1:0]  dst;
        logic [DATA_W-1:0] data;
    } slot_t;

    slot_t          mem [DEPTH];
    logic [AW-1:0]  rd_ptr;
    logic [AW-1:0]  wr_ptr;
    logic [CW-1:0]  cnt;
    logic           do_push;
    logic           do_pop;

    assign ready      = (cnt != CW'(DEPTH));
    assign head_valid = (cnt != '0);
    assign do_push    = push && ready;
    assign do_pop     = pop && head_valid;
    assign head_dst   = mem[rd_ptr].dst;
    assign head_data  = mem[rd_ptr].data;
    assign count      = cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + AW'(1);
            if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= '{dst: push_dst, data: push_data};
    end

endmodule

// File: rtl/pkt_xbar_outfifo.sv
module pkt_xbar_outfifo #(
    parameter int DATA_W = 8,
    parameter int NPORT  = 4,
    parameter int DEPTH  = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NPORT-1:0]             wr_en,
    input  logic [NPORT*DATA_W-1:0]      wr_data,
    input  logic                         pop,
    output logic                         valid,
    output logic [DATA_W-1:0]            head,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int OW = $clog2(NPORT + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     rd_ptr;
    logic [AW-1:0]     wr_ptr;
    logic [CW-1:0]     cnt;
    logic [AW-1:0]     slot [NPORT];
    logic [OW-1:0]     n_wr;
    logic              do_pop;

    assign valid  = (cnt != '0);
    assign do_pop = pop && valid;
    assign head   = mem[rd_ptr];
    assign count  = cnt;

    // Writers in ascending input order take consecutive slots.
    always_comb begin
        logic [OW-1:0] off;
        off = '0;
        for (int i = 0; i < NPORT; i++) begin
            slot[i] = wr_ptr + AW'(off);
            if (wr_en[i]) off = off + OW'(1);
        end
        n_wr = off;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_pop) rd_ptr <= rd_ptr + AW'(1);
            wr_ptr <= wr_ptr + AW'(n_wr);
            cnt    <= cnt + CW'(n_wr) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NPORT; i++) begin
            if (wr_en[i]) mem[slot[i]] <= wr_data[i*DATA_W +: DATA_W];
        end
    end

endmodule

// File: rtl/pkt_xbar_sched.sv
module pkt_xbar_sched
    import pkt_xbar_pkg::*;
#(
    parameter int NPORT = 4,
    parameter int DEPTH = 4,
    parameter int DST_W = 2
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [1:0]                          mode,
    input  logic [NPORT-1:0]                    head_valid,
    input  logic [NPORT*DST_W-1:0]              head_dst,
    input  logic [NPORT*$clog2(DEPTH+1)-1:0]    out_cnt,
    output logic [NPORT*NPORT-1:0]              grant,
    output logic                                mode_err
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0]    free    [NPORT];
    logic [DST_W-1:0] rr_ptr  [NPORT];
    logic [DST_W-1:0] rr_last [NPORT];
    logic [NPORT-1:0] rr_hit;

    assign mode_err = !mode_ok(mode);

    // grant bit i*NPORT+d: input i moves its head into output d this cycle
    always_comb begin
        int dsel;
        int idx;
        grant  = '0;
        rr_hit = '0;
        dsel   = 0;
        idx    = 0;
        for (int d = 0; d < NPORT; d++) begin
            free[d]    = CW'(DEPTH) - out_cnt[d*CW +: CW];
            rr_last[d] = '0;
        end
        if (mode == XB_OPEN) begin
            for (int i = 0; i < NPORT; i++) begin
                if (head_valid[i]) begin
                    dsel = int'(head_dst[i*DST_W +: DST_W]);
                    if (dsel < NPORT && free[dsel] != '0) begin
                        grant[i*NPORT + dsel] = 1'b1;
                        free[dsel] = free[dsel] - CW'(1);
                    end
                end
            end
        end else if (mode == XB_ROUND) begin
            for (int d = 0; d < NPORT; d++) begin
                if (free[d] != '0) begin
                    for (int k = 0; k < NPORT; k++) begin
                        idx = (int'(rr_ptr[d]) + k) % NPORT;
                        if (!rr_hit[d] && head_valid[idx] &&
                            int'(head_dst[idx*DST_W +: DST_W]) == d) begin
                            grant[idx*NPORT + d] = 1'b1;
                            rr_hit[d]  = 1'b1;
                            rr_last[d] = DST_W'(idx);
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int d = 0; d < NPORT; d++) rr_ptr[d] <= '0;
        end else begin
            for (int d = 0; d < NPORT; d++) begin
                if (rr_hit[d]) rr_ptr[d] <= DST_W'(wrap_next(int'(rr_last[d]), NPORT));
            end
        end
    end

endmodule

// File: rtl/pkt_xbar.sv
module pkt_xbar
    import pkt_xbar_pkg::*;
#(
    parameter int NPORT  = 4,
    parameter int DEPTH  = 4,
    parameter int DATA_W = 8,
    parameter int DST_W  = $clog2(NPORT)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [1:0]                mode,
    input  logic [NPORT-1:0]          in_valid,
    input  logic [NPORT*DST_W-1:0]    in_dst,
    input  logic [NPORT*DATA_W-1:0]   in_data,
    output logic [NPORT-1:0]          in_ready,
    input  logic [NPORT-1:0]          out_pop,
    output logic [NPORT-1:0]          out_valid,
    output logic [NPORT*DATA_W-1:0]   out_data,
    output logic                      mode_err
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [NPORT-1:0]          head_valid;
    logic [NPORT*DST_W-1:0]    head_dst;
    logic [NPORT*DATA_W-1:0]   head_data;
    logic [NPORT-1:0]          in_pop;
    logic [NPORT*CW-1:0]       in_cnt_flat;
    logic [NPORT*CW-1:0]       out_cnt_flat;
    logic [NPORT*NPORT-1:0]    grant;
    logic [NPORT-1:0]          col_en [NPORT];

    always_comb begin
        for (int i = 0; i < NPORT; i++) begin
            in_pop[i] = |grant[i*NPORT +: NPORT];
            for (int d = 0; d < NPORT; d++) col_en[d][i] = grant[i*NPORT + d];
        end
    end

    for (genvar i = 0; i < NPORT; i++) begin : g_in
        pkt_xbar_infifo #(
            .DATA_W (DATA_W),
            .DST_W  (DST_W),
            .DEPTH  (DEPTH)
        ) u_q (
            .clk        (clk),
            .rst        (rst),
            .push       (in_valid[i]),
            .push_dst   (in_dst[i*DST_W +: DST_W]),
            .push_data  (in_data[i*DATA_W +: DATA_W]),
            .pop        (in_pop[i]),
            .ready      (in_ready[i]),
            .head_valid (head_valid[i]),
            .head_dst   (head_dst[i*DST_W +: DST_W]),
            .head_data  (head_data[i*DATA_W +: DATA_W]),
            .count      (in_cnt_flat[i*CW +: CW])
        );
    end

    pkt_xbar_sched #(
        .NPORT (NPORT),
        .DEPTH (DEPTH),
        .DST_W (DST_W)
    ) u_sched (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .head_valid (head_valid),
        .head_dst   (head_dst),
        .out_cnt    (out_cnt_flat),
        .grant      (grant),
        .mode_err   (mode_err)
    );

    for (genvar d = 0; d < NPORT; d++) begin : g_out
        pkt_xbar_outfifo #(
            .DATA_W (DATA_W),
            .NPORT  (NPORT),
            .DEPTH  (DEPTH)
        ) u_q (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (col_en[d]),
            .wr_data (head_data),
            .pop     (out_pop[d]),
            .valid   (out_valid[d]),
            .head    (out_data[d*DATA_W +: DATA_W]),
            .count   (out_cnt_flat[d*CW +: CW])
        );
    end

endmodule

// File: rtl/pkt_xbar_chk.sv
module pkt_xbar_chk #(
    parameter int NPORT = 4,
    parameter int DEPTH = 4
) (
    input logic                               clk,
    input logic                               rst,
    input logic [1:0]                         mode,
    input logic [NPORT*NPORT-1:0]             grant,
    input logic [NPORT*$clog2(DEPTH+1)-1:0]   in_cnt_flat,
    input logic [NPORT*$clog2(DEPTH+1)-1:0]   out_cnt_flat,
    input logic [NPORT-1:0]                   in_valid,
    input logic [NPORT-1:0]                   in_ready,
    input logic                               mode_err
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [NPORT-1:0] col [NPORT];

    always_comb begin
        for (int d = 0; d < NPORT; d++)
            for (int i = 0; i < NPORT; i++) col[d][i] = grant[i*NPORT + d];
    end

    for (genvar d = 0; d < NPORT; d++) begin : g_o
        p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
            out_cnt_flat[d*CW +: CW] <= CW'(DEPTH));
        p_rr_one_grant_r7: assert property (@(posedge clk) disable iff (rst)
            (mode == 2'd0) |-> $onehot0(col[d]));
    end

    for (genvar i = 0; i < NPORT; i++) begin : g_i
        p_grant_needs_head_r5: assert property (@(posedge clk) disable iff (rst)
            (|grant[i*NPORT +: NPORT]) |->
                (in_cnt_flat[i*CW +: CW] != '0) && $onehot0(grant[i*NPORT +: NPORT]));
        p_hol_stall_r5: assert property (@(posedge clk) disable iff (rst)
            ((in_cnt_flat[i*CW +: CW] != '0) && !(|grant[i*NPORT +: NPORT]) &&
             !(in_valid[i] && in_ready[i]))
            |=> in_cnt_flat[i*CW +: CW] == $past(in_cnt_flat[i*CW +: CW]));
        p_push_grow_r2: assert property (@(posedge clk) disable iff (rst)
            (in_valid[i] && in_ready[i] && !(|grant[i*NPORT +: NPORT]))
            |=> in_cnt_flat[i*CW +: CW] == $past(in_cnt_flat[i*CW +: CW]) + CW'(1));
    end

    p_err_freeze_r8: assert property (@(posedge clk) disable iff (rst)
        mode_err |-> (grant == '0));

endmodule

bind pkt_xbar pkt_xbar_chk #(.NPORT(NPORT), .DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .mode         (mode),
    .grant        (grant),
    .in_cnt_flat  (in_cnt_flat),
    .out_cnt_flat (out_cnt_flat),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .mode_err     (mode_err)
);

// File: tb/pkt_xbar_bench.sv
module pkt_xbar_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NPORT  = 4;
    localparam int DEPTH  = 4;
    localparam int DATA_W = 8;
    localparam int DST_W  = 2;
    localparam real CLK_NS = 20.0;

    logic                     clk = 1'b0;
    logic                     rst;
    logic [1:0]               mode;
    logic [NPORT-1:0]         in_valid;
    logic [NPORT*DST_W-1:0]   in_dst;
    logic [NPORT*DATA_W-1:0]  in_data;
    logic [NPORT-1:0]         in_ready;
    logic [NPORT-1:0]         out_pop;
    logic [NPORT-1:0]         out_valid;
    logic [NPORT*DATA_W-1:0]  out_data;
    logic                     mode_err;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] sb_q [NPORT][NPORT][$];
    logic [5:0] seq [NPORT];

    always #(CLK_NS/2) clk = ~clk;

    pkt_xbar #(.NPORT(NPORT), .DEPTH(DEPTH), .DATA_W(DATA_W), .DST_W(DST_W)) u_pkt_xbar (
        .clk(clk), .rst(rst), .mode(mode), .in_valid(in_valid), .in_dst(in_dst),
        .in_data(in_data), .in_ready(in_ready), .out_pop(out_pop),
        .out_valid(out_valid), .out_data(out_data), .mode_err(mode_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic drive(input int i, input int d, input logic [7:0] v);
        in_valid[i] = 1'b1;
        in_dst[i*DST_W +: DST_W] = DST_W'(d);
        in_data[i*DATA_W +: DATA_W] = v;
    endtask

    task automatic push_one(input int i, input int d, input logic [7:0] v);
        drive(i, d, v);
        tick();
        in_valid[i] = 1'b0;
    endtask

    task automatic pop_expect(input int d, input logic [7:0] v, input string req);
        chk(out_valid[d] == 1'b1, req, "out_valid", int'(out_valid[d]), 1);
        chk(out_data[d*DATA_W +: DATA_W] == v, req, "out_data",
            int'(out_data[d*DATA_W +: DATA_W]), int'(v));
        out_pop[d] = 1'b1;
        tick();
        out_pop[d] = 1'b0;
    endtask

    function automatic logic [7:0] tag(input int src, input logic [5:0] s);
        return {2'(src), s};
    endfunction

    task automatic sb_take(input int d);
        logic [7:0] v;
        int src;
        v = out_data[d*DATA_W +: DATA_W];
        src = int'(v[7:6]);
        if (sb_q[src][d].size() == 0) begin
            chk(1'b0, "R6", "unexpected packet", int'(v), -1);
        end else begin
            logic [7:0] e;
            e = sb_q[src][d].pop_front();
            chk(v == e, "R6", "pair order", int'(v), int'(e));
        end
    endtask

    initial begin
        #(CLK_NS * 200000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        rst = 1'b1;
        mode = 2'd2;
        in_valid = '0;
        in_dst = '0;
        in_data = '0;
        out_pop = '0;
        for (int i = 0; i < NPORT; i++) seq[i] = '0;
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1: reset state
        chk(out_valid == '0, "R1", "out_valid", int'(out_valid), 0);
        chk(in_ready == '1, "R1", "in_ready", int'(in_ready), 15);
        chk(mode_err == 1'b0, "R1", "mode_err", int'(mode_err), 0);

        // R3/R9/R8: four inputs to output 1, then freeze after one scheduling edge
        for (int i = 0; i < NPORT; i++) drive(i, 1, tag(i, 6'd1));
        tick();
        in_valid = '0;
        chk(out_valid[1] == 1'b0, "R9", "too early", int'(out_valid[1]), 0);
        tick();
        chk(out_valid[1] == 1'b1, "R9", "arrival", int'(out_valid[1]), 1);
        mode = 2'd1;
        #1;
        chk(mode_err == 1'b1, "R8", "mode_err code 1", int'(mode_err), 1);
        for (int i = 0; i < NPORT; i++) pop_expect(1, tag(i, 6'd1), "R3");
        chk(out_valid[1] == 1'b0, "R3", "drained", int'(out_valid[1]), 0);
        mode = 2'd3;
        #1;
        chk(mode_err == 1'b1, "R8", "mode_err code 3", int'(mode_err), 1);
        mode = 2'd2;
        #1;
        chk(mode_err == 1'b0, "R8", "mode_err code 2", int'(mode_err), 0);

        // R4: one free slot, inputs 1 and 3 contend
        push_one(0, 2, 8'h00);
        push_one(0, 2, 8'h01);
        push_one(0, 2, 8'h02);
        drive(1, 2, 8'h50);
        drive(3, 2, 8'hF0);
        tick();
        in_valid = '0;
        repeat (3) tick();
        pop_expect(2, 8'h00, "R4");
        pop_expect(2, 8'h01, "R4");
        pop_expect(2, 8'h02, "R4");
        pop_expect(2, 8'h50, "R4");
        pop_expect(2, 8'hF0, "R4");

        // R5/R2: blocked head, full input queue, dropped push
        for (int k = 0; k < 4; k++) push_one(1, 2, 8'h60 + 8'(k));
        repeat (3) tick();
        push_one(0, 2, 8'h10);
        push_one(0, 3, 8'h11);
        repeat (4) tick();
        chk(out_valid[3] == 1'b0, "R5", "no bypass", int'(out_valid[3]), 0);
        push_one(0, 3, 8'h12);
        push_one(0, 3, 8'h13);
        chk(in_ready[0] == 1'b0, "R2", "full ready", int'(in_ready[0]), 0);
        push_one(0, 3, 8'h14);
        tick();
        for (int k = 0; k < 4; k++) pop_expect(2, 8'h60 + 8'(k), "R6");
        pop_expect(2, 8'h10, "R5");
        pop_expect(3, 8'h11, "R5");
        pop_expect(3, 8'h12, "R2");
        pop_expect(3, 8'h13, "R2");
        repeat (3) tick();
        chk(out_valid[3] == 1'b0, "R2", "dropped push", int'(out_valid[3]), 0);
        chk(in_ready[0] == 1'b1, "R2", "ready again", int'(in_ready[0]), 1);

        // R7: round-robin rotation and single grant per cycle
        mode = 2'd0;
        push_one(2, 0, 8'h20);
        repeat (2) tick();
        pop_expect(0, 8'h20, "R7");
        for (int i = 0; i < NPORT; i++) drive(i, 0, 8'h30 + 8'(i));
        tick();
        in_valid = '0;
        tick();
        mode = 2'd1;
        pop_expect(0, 8'h33, "R7");
        chk(out_valid[0] == 1'b0, "R7", "one grant", int'(out_valid[0]), 0);
        mode = 2'd0;
        tick();
        pop_expect(0, 8'h30, "R7");
        pop_expect(0, 8'h31, "R7");
        pop_expect(0, 8'h32, "R7");

        // R6: random traffic under both policies, scoreboard per pair
        begin
            int unused;
            unused = int'($urandom(32'h5eed));
        end
        for (int cyc = 0; cyc < 4000; cyc++) begin
            mode = ((cyc / 500) % 2 == 0) ? 2'd2 : 2'd0;
            for (int d = 0; d < NPORT; d++) begin
                if (out_valid[d] && ($urandom % 10) < 4) begin
                    sb_take(d);
                    out_pop[d] = 1'b1;
                end else begin
                    out_pop[d] = 1'b0;
                end
            end
            for (int i = 0; i < NPORT; i++) begin
                if (in_ready[i] && ($urandom % 2) == 1) begin
                    int d;
                    d = int'($urandom % NPORT);
                    drive(i, d, tag(i, seq[i]));
                    sb_q[i][d].push_back(tag(i, seq[i]));
                    seq[i] = seq[i] + 6'd1;
                end else begin
                    in_valid[i] = 1'b0;
                end
            end
            tick();
        end
        in_valid = '0;
        for (int cyc = 0; cyc < 300; cyc++) begin
            for (int d = 0; d < NPORT; d++) begin
                if (out_valid[d]) begin
                    sb_take(d);
                    out_pop[d] = 1'b1;
                end else begin
                    out_pop[d] = 1'b0;
                end
            end
            tick();
        end
        out_pop = '0;
        for (int s = 0; s < NPORT; s++)
            for (int d = 0; d < NPORT; d++)
                chk(sb_q[s][d].size() == 0, "R6", "lost packets",
                    sb_q[s][d].size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule